// File: doc/BRIEF.md
# Low-Voltage Detect Filter Controller

This block is the digital half of a supply-voltage monitor. An analog front end supplies four comparator results: for each of two tolerance settings, a signal saying the supply is below the trip level and a signal saying it is above the recovery level. A software-written tolerance-select bit picks which pair the block uses. A dip is reported only when it lasts long enough. While the supply sits in the hysteresis band between trip and recovery, the flag keeps its value. It clears only once the supply climbs above the recovery level.

The undervoltage flag can be read by software. If configuration allows, it also drives a reset request to the system reset sequencer. That request also works while the device is in wait mode, as long as the monitor has been configured to stay powered there. The block raises no interrupt. The comparator inputs are asynchronous and pass through a two-stage synchronizer before the filter.

Top module: `lv_supervisor`

## Requirements
- R1: After reset, the tolerance select reads 0 (loose pair), the undervoltage flag reads 0 and the reset request is 0.
- R2: Writing 1 to the tolerance select makes the block use the tight pair (`tight_below`, `tight_above`). Writing 0 makes it use the loose pair (`loose_below`, `loose_above`). The pair that is not selected has no effect on the flag.
- R3: If the selected below-trip input has been high for fewer than 32 clock cycles, the flag stays 0. Any cycle with the input low restarts the count from zero.
- R4: If the selected below-trip input stays high, the flag becomes 1 at the 38th rising edge after the input changes. That is two synchronizer stages plus a count that reaches 36. The flag is therefore 1 by 40 cycles.
- R5: While the selected above-recovery input is high and the below-trip input is low, the flag is 0. After the input rises, the flag clears by the 3rd rising edge.
- R6: While neither selected input is high (hysteresis band), the flag keeps its previous value.
- R7: `reset_req` is 1 exactly when the flag is 1 and `cfg_rst_en` is 1. It responds to `cfg_rst_en` in the same cycle.
- R8: While `wait_mode` is 1 and `cfg_pwr_en` is 0, the monitor is off: the flag and the filter count are held at 0 and no reset request is raised. With `cfg_pwr_en` at 1, the monitor keeps filtering during wait mode and can raise `reset_req`.
- R9: Switching the tolerance select to a pair whose below-trip input is already high starts the filter. If this lasts, it sets the flag 36 edges after the write edge and raises a reset request if one is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tight_below | input | 1 | Supply below the tight trip level (async) |
| tight_above | input | 1 | Supply above the tight recovery level (async) |
| loose_below | input | 1 | Supply below the loose trip level (async) |
| loose_above | input | 1 | Supply above the loose recovery level (async) |
| sel_wr | input | 1 | Write strobe for the tolerance select |
| sel_wdata | input | 1 | Value written to the tolerance select (1 = tight, 0 = loose) |
| wait_mode | input | 1 | Device is in wait mode |
| cfg_pwr_en | input | 1 | Keep the monitor active in wait mode |
| cfg_rst_en | input | 1 | Allow the flag to request a reset |
| sel_q | output | 1 | Readback of the tolerance select |
| low_flag | output | 1 | Filtered undervoltage status |
| reset_req | output | 1 | Reset request to the reset sequencer |

## Verification
A filter count that is off by a few, or never cleared, shows up at the ports as a flag that rises early after short dips or that rises after separate short dips added together. Checks at edge 31 and edge 41 of a continuous low catch this within one window. A wrong hold or clear path shows up as a flag that changes inside the band, or that survives three edges above recovery. A monitor that is not frozen while off shows up as a flag or reset request in the first cycle of wait mode.

// File: rtl/lv_supervisor.sv
module lv_supervisor #(
  parameter int CNT_W      = 6,
  parameter int TRIP_COUNT = 36
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tight_below,
  input  logic tight_above,
  input  logic loose_below,
  input  logic loose_above,
  input  logic sel_wr,
  input  logic sel_wdata,
  input  logic wait_mode,
  input  logic cfg_pwr_en,
  input  logic cfg_rst_en,
  output logic sel_q,
  output logic low_flag,
  output logic reset_req
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] SET_AT  = CNT_W'(TRIP_COUNT - 1);

  logic [3:0]       meta_q, sync_q;
  logic [CNT_W-1:0] cnt;
  logic             below_s, above_s, active;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= {tight_below, tight_above, loose_below, loose_above};
      sync_q <= meta_q;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      sel_q <= 1'b0;
    else if (sel_wr) sel_q <= sel_wdata;

  assign below_s = sel_q ? sync_q[3] : sync_q[1];
  assign above_s = sel_q ? sync_q[2] : sync_q[0];
  assign active  = !(wait_mode && !cfg_pwr_en);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)            cnt <= '0;
    else if (!active)      cnt <= '0;
    else if (!below_s)     cnt <= '0;
    else if (cnt != CNT_MAX) cnt <= cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                         low_flag <= 1'b0;
    else if (!active)                   low_flag <= 1'b0;
    else if (below_s && cnt >= SET_AT)  low_flag <= 1'b1;
    else if (above_s && !below_s)       low_flag <= 1'b0;

  assign reset_req = cfg_rst_en & low_flag;

  assert_count_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!below_s) |=> (cnt == '0));

  assert_rise_after_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(low_flag) |-> ($past(below_s) && $past(active)));

  assert_clear_above_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (active && above_s && !below_s) |=> !low_flag);

  assert_hold_band_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !above_s && !below_s) |=> $stable(low_flag));

  assert_off_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!active) |=> (cnt == '0 && !low_flag));

endmodule

// File: tb/lv_supervisor_tb.sv
module lv_supervisor_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tight_below = 0, tight_above = 0, loose_below = 0, loose_above = 0;
  logic sel_wr = 0, sel_wdata = 0, wait_mode = 0, cfg_pwr_en = 0, cfg_rst_en = 0;
  logic sel_q, low_flag, reset_req;
  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  lv_supervisor dut_i (
    .clk(clk), .rst_n(rst_n),
    .tight_below(tight_below), .tight_above(tight_above),
    .loose_below(loose_below), .loose_above(loose_above),
    .sel_wr(sel_wr), .sel_wdata(sel_wdata),
    .wait_mode(wait_mode), .cfg_pwr_en(cfg_pwr_en), .cfg_rst_en(cfg_rst_en),
    .sel_q(sel_q), .low_flag(low_flag), .reset_req(reset_req)
  );

  // {tight_below, tight_above, loose_below, loose_above, cycles[7:0], expected flag}
  localparam int NV = 8;
  localparam logic [12:0] VEC [0:NV-1] = '{
    {4'b0000, 8'd5,  1'b0},  // R6 band from reset
    {4'b0010, 8'd30, 1'b0},  // R3 short dip
    {4'b0000, 8'd5,  1'b0},  // R3 restart
    {4'b0010, 8'd30, 1'b0},  // R3 not cumulative
    {4'b0010, 8'd12, 1'b1},  // R4 sustained, 42 edges
    {4'b0000, 8'd10, 1'b1},  // R6 hold in band
    {4'b0001, 8'd4,  1'b0},  // R5 recovery
    {4'b1000, 8'd45, 1'b0}   // R2 unselected pair ignored
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic write_sel(input logic v);
    sel_wr = 1; sel_wdata = v;
    step(1);
    sel_wr = 0;
  endtask

  task automatic set_in(input logic [3:0] v);
    {tight_below, tight_above, loose_below, loose_above} = v;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    step(2);
    rst_n = 1;
    step(1);
    check("R1 sel", sel_q, 1'b0);
    check("R1 flag", low_flag, 1'b0);
    check("R1 req", reset_req, 1'b0);

    for (int i = 0; i < NV; i++) begin
      set_in(VEC[i][12:9]);
      step(int'(VEC[i][8:1]));
      check($sformatf("R2-6 vec%0d", i), low_flag, VEC[i][0]);
    end

    set_in(4'b0000); step(3);
    set_in(4'b0010);
    step(31); check("R3 edge31", low_flag, 1'b0);
    step(10); check("R4 edge41", low_flag, 1'b1);
    set_in(4'b0001);
    step(3);  check("R5 clear by edge3", low_flag, 1'b0);

    set_in(4'b0010);
    write_sel(1'b1);
    check("R2 sel readback", sel_q, 1'b1);
    step(45); check("R2 loose ignored", low_flag, 1'b0);
    cfg_rst_en = 1;
    check("R7 no req without flag", reset_req, 1'b0);
    write_sel(1'b0);
    step(40);
    check("R9 flag after switch", low_flag, 1'b1);
    check("R9 req after switch", reset_req, 1'b1);

    cfg_rst_en = 0; #1;
    check("R7 req off", reset_req, 1'b0);
    cfg_rst_en = 1; #1;
    check("R7 req on", reset_req, 1'b1);

    step(1);
    wait_mode = 1; cfg_pwr_en = 0;
    step(1);
    check("R8 off flag", low_flag, 1'b0);
    check("R8 off req", reset_req, 1'b0);
    step(50);
    check("R8 held off", low_flag, 1'b0);
    cfg_pwr_en = 1;
    step(40);
    check("R8 wait flag", low_flag, 1'b1);
    check("R8 wait req", reset_req, 1'b1);
    wait_mode = 0; cfg_pwr_en = 0;

    set_in(4'b0001); step(3);
    write_sel(1'b1);
    set_in(4'b1000);
    step(45);
    check("R2 tight pair sets", low_flag, 1'b1);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule